// File: doc/BRIEF.md
# Thermostat Alert with Fault Queue

This block watches a stream of 12-bit temperature samples and decides when a thermal alert line should be driven. Every sample that arrives with its valid strobe is compared, as a signed two's-complement number, against a high limit and a low limit. A short saturating counter acts as a fault queue. The alert state changes only after a programmed number of consecutive qualifying samples, so a single noisy reading cannot cause a false alarm.

Two behaviours can be selected. In comparator behaviour the alert follows the temperature with hysteresis. It is raised after enough samples at or above the high limit, and it is dropped after the same number of samples below the low limit. In interrupt behaviour the alert is a latched event. Once raised, it stays up until software reads any register, until this device wins an alert-response transaction on the bus, or until shutdown is entered. After each clear, the armed threshold swaps between the high and the low limit. A cause bit records which limit raised the latest alert, so the bus logic can return it during an alert response.

A true-polarity copy of the alert state is also provided for that responder. The limit and configuration registers and the bus protocol engine all sit outside this block. They drive its inputs.

Top module: `thermo_alert`

## Requirements
- R1: The fault-queue code `cfg_queue` selects the number N of consecutive qualifying samples that changes the alert state: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4, and 2'b11 gives 6.
- R2: A valid sample that does not qualify against the currently armed limit returns the consecutive count to zero, so the next N qualifying samples are needed again.
- R3: With `cfg_intr`=0 (comparator), the alert becomes active after N valid samples with temperature >= high limit. It becomes inactive after N valid samples with temperature < low limit, and not before.
- R4: With `cfg_intr`=1 (interrupt), the alert becomes active after N valid samples >= high limit. While it is active, samples have no effect. It becomes inactive in the cycle after any of `reg_read`, `ara_won` or `shutdown` is high.
- R5: In interrupt mode, each clear swaps the armed limit. After a clear from a high-limit alert, only N samples < low limit raise the next alert. After that alert is cleared, the high limit is armed again.
- R6: With `cfg_pol`=0, `alert_out` is 0 while the alert is active and 1 otherwise. With `cfg_pol`=1, `alert_out` equals the active state.
- R7: Comparisons use all 12 bits as signed two's-complement values. For example, 12'h7FF is above a high limit of 12'hFFE, 12'h800 is below a low limit of 12'hFFC, and a temperature one LSB under the high limit does not qualify.
- R8: `ara_status` is 1 when the latest alert was raised by the high limit and 0 when it was raised by the low limit. It keeps its value until the next raise. `alert_active` gives the active state with true polarity.
- R9: A one-cycle `gc_reset` makes the alert inactive, clears the count and `ara_status`, and arms the high limit. All of this takes effect at the next clock edge.
- R10: After `rst_n` is asserted, the alert is inactive, the high limit is armed, the count is zero and `ara_status` is 0.
- R11: Cycles with `sample_valid`=0 leave the count and the alert state unchanged, whatever the temperature input is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe marking a new temperature sample |
| sample_temp | input | 12 | Signed temperature sample |
| lim_hi | input | 12 | Signed high limit |
| lim_lo | input | 12 | Signed low limit |
| cfg_queue | input | 2 | Fault-queue depth code |
| cfg_intr | input | 1 | 0 = comparator behaviour, 1 = interrupt behaviour |
| cfg_pol | input | 1 | Alert output polarity, 1 = active high |
| reg_read | input | 1 | Pulse: a register was read over the bus |
| ara_won | input | 1 | Pulse: this device won an alert-response transaction |
| shutdown | input | 1 | High when shutdown is entered |
| gc_reset | input | 1 | Pulse: general-call reset |
| alert_out | output | 1 | Alert line with the programmed polarity |
| alert_active | output | 1 | Alert state, active high |
| ara_status | output | 1 | Cause of the latest alert, 1 = high limit |

## Verification
Directed sequences drive runs of samples that stop one short of the queue depth and are then broken by a sample between the limits. These runs separate a true consecutive count from a cumulative one. Samples one LSB on either side of each limit, together with negative limits paired with 12'h7FF and 12'h800, separate a signed comparison from an unsigned one and show whether every bit is used. Interrupt sequences clear the alert in turn with a read, an alert-response win and shutdown. They show that the armed limit alternates and that `ara_status` follows the cause. Random phases then spread samples around both limits, with sparse clears and general-call resets, in each mode and polarity. A bench model compares the results on every cycle.

// File: rtl/thermo_alert_pkg.sv
package thermo_alert_pkg;

  localparam int TEMP_W = 12;
  localparam int CNT_W  = 3;

  // reset values of the external limit registers (80 C / 75 C)
  localparam logic [TEMP_W-1:0] LIM_HI_RST = 12'h500;
  localparam logic [TEMP_W-1:0] LIM_LO_RST = 12'h4B0;

  function automatic logic [CNT_W-1:0] queue_depth(input logic [1:0] code);
    logic [CNT_W-1:0] d;
    case (code)
      2'b00:   d = CNT_W'(1);
      2'b01:   d = CNT_W'(2);
      2'b10:   d = CNT_W'(4);
      default: d = CNT_W'(6);
    endcase
    return d;
  endfunction

endpackage

// File: rtl/thermo_limit_cmp.sv
module thermo_limit_cmp #(
  parameter int TW = 12
) (
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  output logic          at_or_above_hi,
  output logic          below_lo
);

  always_comb begin
    at_or_above_hi = $signed(temp) >= $signed(lim_hi);
    below_lo       = $signed(temp) <  $signed(lim_lo);
  end

endmodule

// File: rtl/thermo_fault_cnt.sv
module thermo_fault_cnt #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          sample_valid,
  input  logic          hit,
  input  logic [CW-1:0] depth,
  output logic          fire
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    fire  = 1'b0;
    cnt_d = cnt_q;
    if (clr || !en) begin
      cnt_d = '0;
    end else if (sample_valid) begin
      if (!hit) begin
        cnt_d = '0;
      end else if ((cnt_q + CW'(1)) >= depth) begin
        fire  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(6));

  // R2
  cnt_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && sample_valid && !hit) |=> (cnt_q == '0));

  // R11
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !sample_valid) |=> $stable(cnt_q));

endmodule

// File: rtl/thermo_alert_fsm.sv
module thermo_alert_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic gc_reset,
  input  logic intr_mode,
  input  logic fire,
  input  logic clr_req,
  output logic active,
  output logic watch_lo,
  output logic cause
);

  logic act_q, act_d;
  logic side_q, side_d;
  logic cause_q, cause_d;

  always_comb begin
    act_d   = act_q;
    side_d  = side_q;
    cause_d = cause_q;
    if (gc_reset) begin
      act_d   = 1'b0;
      side_d  = 1'b0;
      cause_d = 1'b0;
    end else if (intr_mode) begin
      if (act_q && clr_req) begin
        act_d  = 1'b0;
        side_d = ~side_q;
      end else if (!act_q && fire) begin
        act_d   = 1'b1;
        cause_d = ~side_q;
      end
    end else if (fire) begin
      act_d  = ~act_q;
      side_d = ~side_q;
      if (!act_q) cause_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      side_q  <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      side_q  <= side_d;
      cause_q <= cause_d;
    end
  end

  assign active   = act_q;
  assign watch_lo = side_q;
  assign cause    = cause_q;

  // R3
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gc_reset && !intr_mode && !fire) |=> $stable(act_q));

  // R4
  int_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gc_reset && intr_mode && act_q && clr_req) |=> !act_q);

  // R5
  int_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gc_reset && intr_mode && act_q && clr_req) |=> (side_q != $past(side_q)));

  // R8
  cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gc_reset && intr_mode && !act_q && fire) |=> (cause_q == !$past(side_q)));

  // R9
  gc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> (!act_q && !side_q && !cause_q));

endmodule

// File: rtl/thermo_alert.sv
module thermo_alert
  import thermo_alert_pkg::*;
#(
  parameter int TW = TEMP_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_valid,
  input  logic [TW-1:0] sample_temp,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  input  logic [1:0]    cfg_queue,
  input  logic          cfg_intr,
  input  logic          cfg_pol,
  input  logic          reg_read,
  input  logic          ara_won,
  input  logic          shutdown,
  input  logic          gc_reset,
  output logic          alert_out,
  output logic          alert_active,
  output logic          ara_status
);

  logic hi_hit, lo_hit, hit, fire, cnt_en, active, watch_lo, cause;
  logic [CW-1:0] depth;

  thermo_limit_cmp #(.TW(TW)) u_cmp (
    .temp           (sample_temp),
    .lim_hi         (lim_hi),
    .lim_lo         (lim_lo),
    .at_or_above_hi (hi_hit),
    .below_lo       (lo_hit)
  );

  always_comb begin
    depth  = CW'(queue_depth(cfg_queue));
    hit    = watch_lo ? lo_hit : hi_hit;
    cnt_en = !(cfg_intr && active);
  end

  thermo_fault_cnt #(.CW(CW)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (gc_reset),
    .en           (cnt_en),
    .sample_valid (sample_valid),
    .hit          (hit),
    .depth        (depth),
    .fire         (fire)
  );

  thermo_alert_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .gc_reset  (gc_reset),
    .intr_mode (cfg_intr),
    .fire      (fire),
    .clr_req   (reg_read | ara_won | shutdown),
    .active    (active),
    .watch_lo  (watch_lo),
    .cause     (cause)
  );

  always_comb begin
    alert_out    = cfg_pol ? active : ~active;
    alert_active = active;
    ara_status   = cause;
  end

  // R6
  pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_active) |-> (alert_out == cfg_pol));

  // R4
  int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_intr && alert_active && !reg_read && !ara_won && !shutdown && !gc_reset)
      |=> alert_active);

endmodule

// File: tb/thermo_alert_test.sv
module thermo_alert_test;
  import thermo_alert_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vld;
  logic [11:0] t, hi, lo;
  logic [1:0]  q;
  logic        intr, pol, rr, aw, sd, gc;
  logic        alert_out, alert_active, ara_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic m_act, m_side, m_cause;
  int   m_cnt;

  always #5 clk = ~clk;

  thermo_alert uut (
    .clk(clk), .rst_n(rst_n), .sample_valid(vld), .sample_temp(t),
    .lim_hi(hi), .lim_lo(lo), .cfg_queue(q), .cfg_intr(intr), .cfg_pol(pol),
    .reg_read(rr), .ara_won(aw), .shutdown(sd), .gc_reset(gc),
    .alert_out(alert_out), .alert_active(alert_active), .ara_status(ara_status)
  );

  function automatic int depth_of(input logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 6;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic h;
    if (gc) begin
      m_act = 0; m_side = 0; m_cause = 0; m_cnt = 0;
    end else if (intr && m_act) begin
      m_cnt = 0;
      if (rr || aw || sd) begin m_act = 0; m_side = ~m_side; end
    end else if (vld) begin
      h = m_side ? ($signed(t) < $signed(lo)) : ($signed(t) >= $signed(hi));
      if (!h) m_cnt = 0;
      else if (m_cnt + 1 >= depth_of(q)) begin
        m_cnt = 0;
        if (intr) begin m_act = 1; m_cause = ~m_side; end
        else begin
          if (!m_act) m_cause = 1;
          m_act = ~m_act; m_side = ~m_side;
        end
      end else m_cnt++;
    end
  endtask

  // advance one clock, then compare outputs with the model (R1 R2 R3 R4 R5 R6 R8 R11)
  task automatic tick();
    model_step();
    @(posedge clk); #1;
    chk(alert_out == (pol ? m_act : ~m_act), "R6 model alert_out", alert_out, pol ? m_act : ~m_act);
    chk(alert_active == m_act, "R3 R4 R5 model alert_active", alert_active, m_act);
    chk(ara_status == m_cause, "R8 model ara_status", ara_status, m_cause);
    vld = 0; rr = 0; aw = 0; sd = 0; gc = 0;
  endtask

  task automatic samp(input logic [11:0] v);
    vld = 1; t = v; tick();
  endtask

  task automatic expect_act(input logic e, input string tag);
    chk(alert_active == e, tag, alert_active, e);
    chk(alert_out == (pol ? e : ~e), tag, alert_out, pol ? e : ~e);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; vld = 0; t = '0; hi = LIM_HI_RST; lo = LIM_LO_RST;
    q = 2'b00; intr = 0; pol = 0; rr = 0; aw = 0; sd = 0; gc = 0;
    m_act = 0; m_side = 0; m_cause = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(alert_out == 1'b1, "R10 reset alert_out", alert_out, 1);
    chk(alert_active == 1'b0, "R10 reset alert_active", alert_active, 0);
    chk(ara_status == 1'b0, "R10 reset ara_status", ara_status, 0);
    rst_n = 1;

    // R1 R2 R3: comparator, depth 6, broken run then full run
    q = 2'b11;
    repeat (5) samp(12'h500);
    expect_act(0, "R1 five of six high samples");
    samp(12'h4C0);
    repeat (5) samp(12'h600);
    expect_act(0, "R2 count restarted after break");
    samp(12'h600);
    expect_act(1, "R3 sixth consecutive high sample");
    chk(ara_status == 1, "R8 cause high in comparator", ara_status, 1);
    repeat (5) samp(12'h4AF);
    samp(12'h4B0);
    repeat (5) samp(12'h400);
    expect_act(1, "R3 still active before six low samples");
    samp(12'h400);
    expect_act(0, "R3 released after six low samples");

    // R11: no valid strobe, hot temperature, nothing moves
    q = 2'b00; t = 12'h7FF;
    repeat (10) tick();
    expect_act(0, "R11 invalid samples ignored");
    samp(12'h7FF);
    expect_act(1, "R1 depth one asserts at once");
    samp(12'h000);
    expect_act(0, "R3 depth one releases at once");

    // R4 R5 R8: interrupt cycle
    intr = 1; q = 2'b01;
    samp(12'h500); expect_act(0, "R1 depth two first sample");
    samp(12'h500); expect_act(1, "R4 interrupt raise on high");
    chk(ara_status == 1, "R8 cause high", ara_status, 1);
    repeat (3) samp(12'h000);
    expect_act(1, "R4 samples ignored while pending");
    rr = 1; tick();
    expect_act(0, "R4 cleared by register read");
    repeat (4) samp(12'h7F0);
    expect_act(0, "R5 high limit not armed after clear");
    samp(12'h4AF); samp(12'h4AF);
    expect_act(1, "R5 low limit raises alert");
    chk(ara_status == 0, "R8 cause low", ara_status, 0);
    aw = 1; tick();
    expect_act(0, "R4 cleared by alert response win");
    samp(12'h100); samp(12'h100);
    expect_act(0, "R5 low limit not armed again");
    samp(12'h500); samp(12'h500);
    expect_act(1, "R5 high limit armed again");
    sd = 1; tick();
    expect_act(0, "R4 cleared by shutdown");

    // R6: active-high polarity
    pol = 1; intr = 0; q = 2'b00;
    gc = 1; tick();
    samp(12'h650);
    chk(alert_out == 1, "R6 active high alert_out", alert_out, 1);

    // R9: general-call reset while active
    gc = 1; tick();
    expect_act(0, "R9 gc reset clears alert");
    chk(ara_status == 0, "R9 gc reset clears status", ara_status, 0);
    samp(12'h000);
    expect_act(0, "R9 high limit armed after gc");

    // R7: signed and full-width compares
    pol = 0; hi = 12'hFFE; lo = 12'hFFC;
    samp(12'hFFD); expect_act(0, "R7 one LSB under negative high");
    samp(12'h7FF); expect_act(1, "R7 7FF above FFE");
    samp(12'hFFC); expect_act(1, "R7 equal low not below");
    samp(12'h800); expect_act(0, "R7 800 below FFC");
    hi = 12'h501;
    samp(12'h500); expect_act(0, "R7 LSB of high limit used");
    hi = LIM_HI_RST;

    // random phases over both modes and polarities
    for (int ph = 0; ph < 4; ph++) begin
      intr = ph[0]; pol = ph[1]; gc = 1; tick();
      for (int k = 0; k < 3000; k++) begin
        int r, sel;
        if (k % 500 == 0) q = 2'($urandom);
        r   = int'($urandom % 7) - 3;
        sel = int'($urandom % 3);
        vld = ($urandom % 2) == 0;
        t = (sel == 0) ? 12'(hi + 12'(r)) : (sel == 1) ? 12'(lo + 12'(r)) : 12'($urandom);
        rr = ($urandom % 40) == 0;
        aw = ($urandom % 60) == 0;
        sd = ($urandom % 80) == 0;
        gc = ($urandom % 400) == 0;
        tick();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule